// File: doc/BRIEF.md
# Translation-Cache Flush and Fault Interrupt Controller

This block is the control and status part of an I/O address-translation unit. Software reaches it through a 32-bit register port with a write strobe and a combinational read path. It asks for cache invalidation by writing the flush register. Each bit written as one sends a single-cycle start pulse to its target. The targets are one page-walk cache, one shared TLB and one private TLB per master (NM masters, six by default). The request bit then stays readable as one until that target raises its done input. Software polls the flush register until it reads zero.

The walker can report an invalid first-level entry or an invalid second-level entry. The permission checker can report a denied access from a given master. Each such report sets a sticky status bit, and software clears these bits by writing ones to the clear register. Only the first event of a class is captured, into address, data and master-identity registers. The capture stays held until software clears the status bit. A registered level interrupt is raised whenever a status bit is pending and enabled. A registered cause code tells which enabled class is most urgent, in fixed priority order.

Top module: `mmuc_top`

## Requirements
- R1: After reset the flush register (0x080), the enable register (0x100) and the status register (0x108) read zero, and `irq`, `irq_cause` and `flush_go` are zero.
- R2: A write to 0x080 sets a pending bit for each implemented bit written as one: bit 17 for the page-walk cache, bit 16 for the shared TLB and bits NM-1:0 for the per-master TLBs. In the edge that follows, `flush_go` pulses for exactly one cycle on the matching targets. Bits written as zero, and unimplemented bits, have no effect. The `flush_go` index is m for master m, NM for the shared TLB and NM+1 for the page-walk cache.
- R3: A pending flush bit clears in the cycle after its `flush_done` input is high. A done input for a target that is not pending changes nothing. The register reads zero once every requested target is done.
- R4: Writing one to a flush bit that is already pending produces no new `flush_go` pulse.
- R5: Three kinds of event each set a status bit one cycle after the event is presented. A second-level fault sets bit 17 of 0x108, a first-level fault sets bit 16, and a permission fault from master m sets bit m.
- R6: Writing one to a bit of 0x104 clears that status bit. An event of the same class presented in the same cycle wins, and the bit stays set. Register 0x104 reads zero.
- R7: `irq` is high exactly when some status bit is set and its bit in 0x100 is set. `irq` is registered, so it follows status and enable changes in the same cycle they become visible in the registers.
- R8: The fault address of the first-level class (0x130), the fault address of the second-level class (0x134), and the per-master fault address (0x110+4m) and data (0x150+4m) load only when their status bit goes from 0 to 1. Later events of the same class leave them unchanged until the bit is cleared.
- R9: `irq_cause` gives the enabled pending class of highest priority. The codes are 1 for a second-level fault, 2 for a first-level fault, 3 for any permission fault and 0 for none. A second-level fault ranks above a first-level fault, which ranks above permission faults.
- R10: The register 0x180 holds a one-hot mask of the master that caused the captured first-level fault, with bit m set for master m. The register 0x184 does the same for the second-level fault. Both load under the same first-event rule as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| flush_go | output | NM+2 | One-cycle flush start pulses per target |
| flush_done | input | NM+2 | Per-target flush completion |
| l1_fault | input | 1 | Walker reports an invalid first-level entry |
| l2_fault | input | 1 | Walker reports an invalid second-level entry |
| walk_addr | input | 32 | Faulting address from the walker |
| walk_master | input | IW | Master index of the walker fault |
| perm_fault | input | 1 | Permission checker reports a denied access |
| perm_master | input | IW | Master index of the permission fault |
| perm_addr | input | 32 | Faulting address of the permission fault |
| perm_data | input | 32 | Fault data word of the permission fault |
| irq | output | 1 | Level interrupt |
| irq_cause | output | 2 | Highest-priority enabled pending class |

## Verification
Every register sits one edge from its stimulus. A write or an event presented before an edge changes the pending, status, capture and enable registers at that edge. It also changes `flush_go`, `irq` and `irq_cause` at that same edge, because the outputs are computed from next-state values. The bench drives inputs on the falling edge and holds them across one rising edge. It then reads registers and outputs on the next falling edge, so each result is checked in the half-cycle right after the edge that produced it. The one-cycle width of `flush_go` is checked on the falling edge after that.

// File: rtl/mmuc_pkg.sv
package mmuc_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_FLUSH = 12'h080;
    localparam logic [OFS_W-1:0] OFS_INTEN = 12'h100;
    localparam logic [OFS_W-1:0] OFS_INTCL = 12'h104;
    localparam logic [OFS_W-1:0] OFS_INTST = 12'h108;
    localparam logic [OFS_W-1:0] OFS_PADDR = 12'h110;
    localparam logic [OFS_W-1:0] OFS_L1ADR = 12'h130;
    localparam logic [OFS_W-1:0] OFS_L2ADR = 12'h134;
    localparam logic [OFS_W-1:0] OFS_PDATA = 12'h150;
    localparam logic [OFS_W-1:0] OFS_L1WHO = 12'h180;
    localparam logic [OFS_W-1:0] OFS_L2WHO = 12'h184;

    // register bit positions of the two shared classes/targets
    localparam int BIT_LO = 16;
    localparam int BIT_HI = 17;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_L2   = 2'd1,
        CAUSE_L1   = 2'd2,
        CAUSE_PERM = 2'd3
    } cause_e;

endpackage

// File: rtl/mmuc_flush.sv
module mmuc_flush #(
    parameter int NT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_wr,
    input  logic [NT-1:0] req_bits,
    input  logic [NT-1:0] done,
    output logic [NT-1:0] pend,
    output logic [NT-1:0] go
);

    typedef struct packed {
        logic [NT-1:0] pend;
        logic [NT-1:0] go;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NT-1:0] fresh;
        st_d  = st_q;
        fresh = req_wr ? (req_bits & ~st_q.pend) : '0;
        st_d.pend = (st_q.pend & ~done) | fresh;
        st_d.go   = fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign go   = st_q.go;

endmodule

// File: rtl/mmuc_fault.sv
module mmuc_fault
    import mmuc_pkg::*;
#(
    parameter int NM = 6,
    localparam int NT = NM + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NT-1:0]               ev,
    input  logic [REG_W-1:0]            walk_addr,
    input  logic [NM-1:0]               walk_who,
    input  logic [REG_W-1:0]            perm_addr,
    input  logic [REG_W-1:0]            perm_data,
    input  logic                        clr_wr,
    input  logic [NT-1:0]               clr_vec,
    input  logic                        en_wr,
    input  logic [NT-1:0]               en_vec,
    output logic [NT-1:0]               stat,
    output logic [NT-1:0]               en,
    output logic [REG_W-1:0]            l1_addr,
    output logic [REG_W-1:0]            l2_addr,
    output logic [NM-1:0]               l1_who,
    output logic [NM-1:0]               l2_who,
    output logic [NM-1:0][REG_W-1:0]    pa,
    output logic [NM-1:0][REG_W-1:0]    pd,
    output logic                        irq,
    output logic [1:0]                  cause
);

    localparam int IL1 = NM;
    localparam int IL2 = NM + 1;

    typedef struct packed {
        logic [NT-1:0]            stat;
        logic [NT-1:0]            en;
        logic [REG_W-1:0]         l1a;
        logic [REG_W-1:0]         l2a;
        logic [NM-1:0]            l1w;
        logic [NM-1:0]            l2w;
        logic [NM-1:0][REG_W-1:0] pa;
        logic [NM-1:0][REG_W-1:0] pd;
        logic                     irq;
        logic [1:0]               cause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NT-1:0] newset;
        logic [NT-1:0] act;
        st_d   = st_q;
        newset = ev & ~st_q.stat;
        st_d.stat = (st_q.stat & ~(clr_wr ? clr_vec : '0)) | ev;
        if (en_wr) st_d.en = en_vec;

        if (newset[IL1]) begin
            st_d.l1a = walk_addr;
            st_d.l1w = walk_who;
        end
        if (newset[IL2]) begin
            st_d.l2a = walk_addr;
            st_d.l2w = walk_who;
        end
        for (int m = 0; m < NM; m++) begin
            if (newset[m]) begin
                st_d.pa[m] = perm_addr;
                st_d.pd[m] = perm_data;
            end
        end

        act      = st_d.stat & st_d.en;
        st_d.irq = |act;
        if (act[IL2])           st_d.cause = CAUSE_L2;
        else if (act[IL1])      st_d.cause = CAUSE_L1;
        else if (|act[NM-1:0])  st_d.cause = CAUSE_PERM;
        else                    st_d.cause = CAUSE_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat    = st_q.stat;
    assign en      = st_q.en;
    assign l1_addr = st_q.l1a;
    assign l2_addr = st_q.l2a;
    assign l1_who  = st_q.l1w;
    assign l2_who  = st_q.l2w;
    assign pa      = st_q.pa;
    assign pd      = st_q.pd;
    assign irq     = st_q.irq;
    assign cause   = st_q.cause;

endmodule

// File: rtl/mmuc_rdmux.sv
module mmuc_rdmux
    import mmuc_pkg::*;
#(
    parameter int NM = 6,
    localparam int NT = NM + 2
) (
    input  logic [OFS_W-1:0]            addr,
    input  logic [NT-1:0]               pend,
    input  logic [NT-1:0]               en,
    input  logic [NT-1:0]               stat,
    input  logic [REG_W-1:0]            l1_addr,
    input  logic [REG_W-1:0]            l2_addr,
    input  logic [NM-1:0]               l1_who,
    input  logic [NM-1:0]               l2_who,
    input  logic [NM-1:0][REG_W-1:0]    pa,
    input  logic [NM-1:0][REG_W-1:0]    pd,
    output logic [REG_W-1:0]            rdata
);

    function automatic logic [REG_W-1:0] to_reg(input logic [NT-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[NM-1:0] = v[NM-1:0];
        r[BIT_LO] = v[NM];
        r[BIT_HI] = v[NM+1];
        return r;
    endfunction

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_FLUSH: rdata = to_reg(pend);
            OFS_INTEN: rdata = to_reg(en);
            OFS_INTST: rdata = to_reg(stat);
            OFS_L1ADR: rdata = l1_addr;
            OFS_L2ADR: rdata = l2_addr;
            OFS_L1WHO: rdata = REG_W'(l1_who);
            OFS_L2WHO: rdata = REG_W'(l2_who);
            default:   rdata = '0;
        endcase
        for (int m = 0; m < NM; m++) begin
            if (addr == OFS_PADDR + OFS_W'(4 * m)) rdata = pa[m];
            if (addr == OFS_PDATA + OFS_W'(4 * m)) rdata = pd[m];
        end
    end

endmodule

// File: rtl/mmuc_top.sv
module mmuc_top
    import mmuc_pkg::*;
#(
    parameter int NM = 6,
    localparam int NT = NM + 2,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [11:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [NT-1:0]    flush_go,
    input  logic [NT-1:0]    flush_done,
    input  logic             l1_fault,
    input  logic             l2_fault,
    input  logic [31:0]      walk_addr,
    input  logic [IW-1:0]    walk_master,
    input  logic             perm_fault,
    input  logic [IW-1:0]    perm_master,
    input  logic [31:0]      perm_addr,
    input  logic [31:0]      perm_data,
    output logic             irq,
    output logic [1:0]       irq_cause
);

    logic [NT-1:0]            wvec;
    logic [NT-1:0]            ev;
    logic [NM-1:0]            walk_who;
    logic [NT-1:0]            pend_w;
    logic [NT-1:0]            stat_w;
    logic [NT-1:0]            en_w;
    logic [REG_W-1:0]         l1_addr_w;
    logic [REG_W-1:0]         l2_addr_w;
    logic [NM-1:0]            l1_who_w;
    logic [NM-1:0]            l2_who_w;
    logic [NM-1:0][REG_W-1:0] pa_w;
    logic [NM-1:0][REG_W-1:0] pd_w;

    // register layout -> internal target/class vector
    always_comb begin
        wvec = '0;
        wvec[NM-1:0] = reg_wdata[NM-1:0];
        wvec[NM]     = reg_wdata[BIT_LO];
        wvec[NM+1]   = reg_wdata[BIT_HI];
    end

    always_comb begin
        ev       = '0;
        walk_who = '0;
        for (int m = 0; m < NM; m++) begin
            ev[m]       = perm_fault && (perm_master == IW'(m));
            walk_who[m] = (walk_master == IW'(m));
        end
        ev[NM]   = l1_fault;
        ev[NM+1] = l2_fault;
    end

    mmuc_flush #(.NT(NT)) u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (reg_wr && reg_addr == OFS_FLUSH),
        .req_bits (wvec),
        .done     (flush_done),
        .pend     (pend_w),
        .go       (flush_go)
    );

    mmuc_fault #(.NM(NM)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .walk_addr (walk_addr),
        .walk_who  (walk_who),
        .perm_addr (perm_addr),
        .perm_data (perm_data),
        .clr_wr    (reg_wr && reg_addr == OFS_INTCL),
        .clr_vec   (wvec),
        .en_wr     (reg_wr && reg_addr == OFS_INTEN),
        .en_vec    (wvec),
        .stat      (stat_w),
        .en        (en_w),
        .l1_addr   (l1_addr_w),
        .l2_addr   (l2_addr_w),
        .l1_who    (l1_who_w),
        .l2_who    (l2_who_w),
        .pa        (pa_w),
        .pd        (pd_w),
        .irq       (irq),
        .cause     (irq_cause)
    );

    mmuc_rdmux #(.NM(NM)) u_rd (
        .addr    (reg_addr),
        .pend    (pend_w),
        .en      (en_w),
        .stat    (stat_w),
        .l1_addr (l1_addr_w),
        .l2_addr (l2_addr_w),
        .l1_who  (l1_who_w),
        .l2_who  (l2_who_w),
        .pa      (pa_w),
        .pd      (pd_w),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/mmuc_chk.sv
module mmuc_chk #(
    parameter int NM = 6,
    localparam int NT = NM + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NT-1:0] flush_go,
    input logic [NT-1:0] pend_w,
    input logic          l1_fault,
    input logic [NT-1:0] stat_w,
    input logic [NT-1:0] en_w,
    input logic [31:0]   l1_addr_w,
    input logic          irq,
    input logic [1:0]    irq_cause
);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_go) |=> ((flush_go & $past(flush_go)) == '0));

    assert_go_means_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_go) |-> ((flush_go & ~pend_w) == '0));

    assert_l1_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        l1_fault |=> stat_w[NM]);

    assert_first_capture_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[NM] && $past(stat_w[NM])) |-> $stable(l1_addr_w));

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_cause != 2'd0));

    assert_no_irq_no_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_cause == 2'd0));

    assert_l2_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[NM+1] && en_w[NM+1]) |-> (irq_cause == 2'd1));

endmodule

bind mmuc_top mmuc_chk #(.NM(NM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_go  (flush_go),
    .pend_w    (pend_w),
    .l1_fault  (l1_fault),
    .stat_w    (stat_w),
    .en_w      (en_w),
    .l1_addr_w (l1_addr_w),
    .irq       (irq),
    .irq_cause (irq_cause)
);

// File: tb/sim_mmuc_top.sv
`timescale 1ns/1ps
module sim_mmuc_top;

    localparam int NM = 6;
    localparam int NT = NM + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NT-1:0] flush_go;
    logic [NT-1:0] flush_done = '0;
    logic          l1_fault = 1'b0;
    logic          l2_fault = 1'b0;
    logic [31:0]   walk_addr = '0;
    logic [2:0]    walk_master = '0;
    logic          perm_fault = 1'b0;
    logic [2:0]    perm_master = '0;
    logic [31:0]   perm_addr = '0;
    logic [31:0]   perm_data = '0;
    logic          irq;
    logic [1:0]    irq_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mmuc_top #(.NM(NM)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flush_go(flush_go),
        .flush_done(flush_done), .l1_fault(l1_fault), .l2_fault(l2_fault),
        .walk_addr(walk_addr), .walk_master(walk_master), .perm_fault(perm_fault),
        .perm_master(perm_master), .perm_addr(perm_addr), .perm_data(perm_data),
        .irq(irq), .irq_cause(irq_cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic done_pulse(input logic [NT-1:0] v);
        @(negedge clk);
        flush_done = v;
        @(negedge clk);
        flush_done = '0;
    endtask

    task automatic walk_ev(input bit lvl2, input logic [31:0] a, input logic [2:0] who);
        @(negedge clk);
        if (lvl2) l2_fault = 1'b1; else l1_fault = 1'b1;
        walk_addr = a; walk_master = who;
        @(negedge clk);
        l1_fault = 1'b0; l2_fault = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h080, v); chk("R1 flush reg", v, 0);
        rd(12'h100, v); chk("R1 enable reg", v, 0);
        rd(12'h108, v); chk("R1 status reg", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 cause", {30'd0, irq_cause}, 0);
        chk("R1 flush_go", {24'd0, flush_go}, 0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr(12'h080, 32'h0013_0005);
        chk("R2 go pulse", {24'd0, flush_go}, 32'hC5);
        rd(12'h080, v); chk("R2 pending", v, 32'h0003_0005);
        @(negedge clk);
        chk("R2 go one cycle", {24'd0, flush_go}, 0);
        wr(12'h080, 32'h0000_0001);
        chk("R4 no repulse", {24'd0, flush_go}, 0);
        done_pulse(8'h01);
        rd(12'h080, v); chk("R3 master0 done", v, 32'h0003_0004);
        done_pulse(8'hC0);
        rd(12'h080, v); chk("R3 shared+walk done", v, 32'h0000_0004);
        done_pulse(8'h02);
        rd(12'h080, v); chk("R3 idle done ignored", v, 32'h0000_0004);
        done_pulse(8'h04);
        rd(12'h080, v); chk("R3 all done", v, 0);
        wr(12'h080, 32'h0000_0000);
        chk("R2 zero write", {24'd0, flush_go}, 0);
    endtask

    task automatic t_walk();
        logic [31:0] v;
        walk_ev(1'b0, 32'hA000_1000, 3'd3);
        rd(12'h108, v); chk("R5 l1 status", v, 32'h0001_0000);
        chk("R7 masked irq", {31'd0, irq}, 0);
        rd(12'h130, v); chk("R8 l1 addr", v, 32'hA000_1000);
        rd(12'h180, v); chk("R10 l1 master", v, 32'h08);
        walk_ev(1'b0, 32'hA000_2000, 3'd1);
        rd(12'h130, v); chk("R8 l1 addr kept", v, 32'hA000_1000);
        rd(12'h180, v); chk("R10 l1 master kept", v, 32'h08);
        wr(12'h100, 32'h0003_003F);
        chk("R7 irq on enable", {31'd0, irq}, 1);
        chk("R9 cause l1", {30'd0, irq_cause}, 2);
        walk_ev(1'b1, 32'hB000_3000, 3'd1);
        rd(12'h108, v); chk("R5 l2 status", v, 32'h0003_0000);
        chk("R9 cause l2 first", {30'd0, irq_cause}, 1);
        rd(12'h134, v); chk("R8 l2 addr", v, 32'hB000_3000);
        rd(12'h184, v); chk("R10 l2 master", v, 32'h02);
        wr(12'h104, 32'h0002_0000);
        chk("R9 cause back to l1", {30'd0, irq_cause}, 2);
        rd(12'h104, v); chk("R6 clear reads zero", v, 0);
        // clear and new event in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h104; reg_wdata = 32'h0001_0000;
        l1_fault = 1'b1; walk_addr = 32'hC000_0000; walk_master = 3'd0;
        @(negedge clk);
        reg_wr = 1'b0; l1_fault = 1'b0;
        rd(12'h108, v); chk("R6 event wins", v, 32'h0001_0000);
        rd(12'h130, v); chk("R8 no reload", v, 32'hA000_1000);
        wr(12'h104, 32'h0001_0000);
        rd(12'h108, v); chk("R6 cleared", v, 0);
        chk("R7 irq low", {31'd0, irq}, 0);
        walk_ev(1'b0, 32'hD000_4000, 3'd5);
        rd(12'h130, v); chk("R8 rearmed", v, 32'hD000_4000);
        rd(12'h180, v); chk("R10 new master", v, 32'h20);
        wr(12'h104, 32'h0001_0000);
    endtask

    task automatic t_perm();
        logic [31:0] v;
        @(negedge clk);
        perm_fault = 1'b1; perm_master = 3'd4;
        perm_addr = 32'h1234_5000; perm_data = 32'h0000_00A5;
        @(negedge clk);
        perm_fault = 1'b0;
        rd(12'h108, v); chk("R5 perm status", v, 32'h10);
        rd(12'h120, v); chk("R8 perm addr", v, 32'h1234_5000);
        rd(12'h160, v); chk("R8 perm data", v, 32'hA5);
        chk("R9 cause perm", {30'd0, irq_cause}, 3);
        chk("R7 irq perm", {31'd0, irq}, 1);
        wr(12'h100, 32'h0000_0000);
        chk("R7 irq disabled", {31'd0, irq}, 0);
        wr(12'h104, 32'h0000_0010);
        rd(12'h108, v); chk("R6 perm cleared", v, 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flush();
        t_walk();
        t_perm();
        finished = 1'b1;
        report();
    end

endmodule